// File: doc/BRIEF.md
# Set/Clear GPIO Bank

A bank of general-purpose pins driven through a small word-addressed register bus. Each pin has an output latch, an output-enable flag and a synchronized input sample. Software never reads back or rewrites a whole latch word. It writes a bit mask to a drive-high or drive-low register, and only the pins whose mask bit is 1 change. Either of those writes also turns the selected pins into outputs. A separate float register turns output drivers off, so the selected pins become inputs.

Live pin levels come from a level register. Each input passes through a two-flop synchronizer before it can be read. The read path stays gated to zero until software has written the arm register at least once since reset. The data value of that write has no effect.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every `pin_oe` bit is 0, every `pin_out` bit is 0, `bus_rvalid` is 0, and the input gate is disarmed.
- R2: A write to word address 0 (drive-high) sets `pin_out[i]` to 1 for every i whose mask bit is 1. The change is visible in the cycle after the write edge, and pins with mask bit 0 keep their value.
- R3: A write to word address 1 (drive-low) sets `pin_out[i]` to 0 for every i whose mask bit is 1, with the same timing. Pins with mask bit 0 keep their value.
- R4: A write to address 0 or address 1 also sets `pin_oe[i]` for every masked pin, and leaves other enables unchanged.
- R5: A write to word address 2 (float) clears `pin_oe[i]` for every masked pin. It leaves `pin_out` and the other enables unchanged.
- R6: A read of word address 3 (level) returns, for an armed bank, the value of `pin_in` after a two-register synchronizer. A pin change applied before edge k is returned by a read captured at edge k+2 or later, and is not returned by a read captured at edge k+1.
- R7: Until a write to word address 4 (arm) has occurred since reset, level reads return 0. The data word of the arm write is ignored, and the bank stays armed until the next reset.
- R8: A read (`bus_vld`=1, `bus_wr`=0) sets `bus_rvalid` for exactly the following cycle, with `bus_rdata` valid then. Reads of addresses 0, 1, 2, 4 and of unmapped addresses 5 to 7 return 0.
- R9: Writes to address 3 or to addresses 5 to 7 change neither `pin_out` nor `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_vld | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | NPINS (32) | Write mask / data |
| bus_rdata | output | NPINS (32) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| pin_in | input | NPINS (32) | Asynchronous pin levels |
| pin_out | output | NPINS (32) | Output latch per pin |
| pin_oe | output | NPINS (32) | Output driver enable per pin |

## Verification
The latches and enables drive the ports directly. A wrong latch or enable bit is therefore visible on `pin_out` or `pin_oe` in the cycle after the offending write. The bench compares both full words after every write, so a stray bit on an unmasked pin is caught at once. Input-side state shows up only through level reads, one cycle after each read. The bench times reads around a pin change to expose a missing or extra synchronizer stage. It also reads before and after arming, and again after a second reset, to show a stuck or mis-reset gate.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register selectors for the set/clear GPIO bank.
// Assumes a word-addressed bus; selector values are the word addresses.
package gpio_bank_pkg;
    typedef enum logic [2:0] {
        SEL_DRIVE_HI = 3'd0,
        SEL_DRIVE_LO = 3'd1,
        SEL_FLOAT    = 3'd2,
        SEL_LEVEL    = 3'd3,
        SEL_ARM      = 3'd4
    } reg_sel_e;

    localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/gpio_bus_decode.sv
// Module: turns one bus beat into single-cycle strobes.
// Assumes bus_vld qualifies bus_wr/bus_addr in the same cycle; no wait states.
module gpio_bus_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              bus_vld,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit_hi,
    output logic              hit_lo,
    output logic              hit_float,
    output logic              hit_arm,
    output logic              rd_any,
    output logic              rd_level
);
    localparam int unsigned UPPER_W = (ADDR_W > SEL_W) ? ADDR_W - SEL_W : 1;

    logic             in_window;
    logic [SEL_W-1:0] sel;
    logic             wr_beat;

    // Split the address into the selector and an upper "must be zero" part.
    generate
        if (ADDR_W > SEL_W) begin : g_wide
            logic [UPPER_W-1:0] upper;
            always_comb begin
                upper     = bus_addr[ADDR_W-1:SEL_W];
                sel       = bus_addr[SEL_W-1:0];
                in_window = (upper == '0);
            end
        end else begin : g_narrow
            always_comb begin
                sel       = '0;
                sel[ADDR_W-1:0] = bus_addr;
                in_window = 1'b1;
            end
        end
    endgenerate

    // Produce the write and read strobes for each register.
    always_comb begin
        wr_beat   = bus_vld && bus_wr && in_window;
        hit_hi    = wr_beat && (sel == SEL_DRIVE_HI);
        hit_lo    = wr_beat && (sel == SEL_DRIVE_LO);
        hit_float = wr_beat && (sel == SEL_FLOAT);
        hit_arm   = wr_beat && (sel == SEL_ARM);
        rd_any    = bus_vld && !bus_wr;
        rd_level  = rd_any && in_window && (sel == SEL_LEVEL);
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module: per-pin output latch and driver enable.
// Assumes at most one of hit_hi/hit_lo/hit_float is set in a cycle (one bus beat).
module gpio_pin_ctrl #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_hi,
    input  logic             hit_lo,
    input  logic             hit_float,
    input  logic [NPINS-1:0] mask,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            logic sel_i;
            logic out_q;
            logic oe_q;

            // Pin i is addressed by the current beat.
            always_comb sel_i = mask[i];

            // Output latch: drive-high sets, drive-low clears.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    out_q <= 1'b0;
                else if (sel_i && hit_hi)
                    out_q <= 1'b1;
                else if (sel_i && hit_lo)
                    out_q <= 1'b0;
            end

            // Driver enable: any drive write turns it on, float turns it off.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    oe_q <= 1'b0;
                else if (sel_i && (hit_hi || hit_lo))
                    oe_q <= 1'b1;
                else if (sel_i && hit_float)
                    oe_q <= 1'b0;
            end

            assign pin_out[i] = out_q;
            assign pin_oe[i]  = oe_q;
        end
    endgenerate
endmodule

// File: rtl/gpio_input_sync.sv
// Module: multi-stage input synchronizer with a one-time arm gate.
// Assumes pin_in is asynchronous; the gate arms on any arm write and holds to reset.
module gpio_input_sync #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_arm,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level
);
    logic [NPINS-1:0] stage_q [STAGES];
    logic             armed_q;

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q[0] <= '0;
        else
            stage_q[0] <= pin_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Further stages shift the sample toward the read side.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else
                    stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    // Arm flag: set by the first arm write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (hit_arm)
            armed_q <= 1'b1;
    end

    // Gate the synchronized sample until armed.
    always_comb level = armed_q ? stage_q[STAGES-1] : '0;
endmodule

// File: rtl/gpio_setclr_bank.sv
// Module: top of the set/clear GPIO bank.
// Assumes single-beat writes and one-cycle registered read data; only the
// level register is readable, all others read as zero.
module gpio_setclr_bank #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);
    localparam int unsigned SYNC_STAGES = 2;

    logic             hit_hi;
    logic             hit_lo;
    logic             hit_float;
    logic             hit_arm;
    logic             rd_any;
    logic             rd_level;
    logic [NPINS-1:0] level;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_vld   (bus_vld),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .hit_hi    (hit_hi),
        .hit_lo    (hit_lo),
        .hit_float (hit_float),
        .hit_arm   (hit_arm),
        .rd_any    (rd_any),
        .rd_level  (rd_level)
    );

    gpio_pin_ctrl #(.NPINS(NPINS)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_hi    (hit_hi),
        .hit_lo    (hit_lo),
        .hit_float (hit_float),
        .mask      (bus_wdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    gpio_input_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_arm (hit_arm),
        .pin_in  (pin_in),
        .level   (level)
    );

    // Register read data and its valid flag one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_any;
            bus_rdata  <= rd_level ? level : '0;
        end
    end
endmodule

// File: rtl/gpio_setclr_bank_chk.sv
// Module: assertion checker bound to gpio_setclr_bank.
// Assumes the same port names as the top; keeps its own arm shadow from the bus.
module gpio_setclr_bank_chk #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_vld,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic              bus_rvalid,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);
    logic seen_arm;
    logic wr_hi, wr_lo, wr_fl, wr_pin;

    // Shadow of the arm gate as seen from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_arm <= 1'b0;
        else if (bus_vld && bus_wr && bus_addr == ADDR_W'(4))
            seen_arm <= 1'b1;
    end

    // Classify the current beat.
    always_comb begin
        wr_hi  = bus_vld && bus_wr && bus_addr == ADDR_W'(0);
        wr_lo  = bus_vld && bus_wr && bus_addr == ADDR_W'(1);
        wr_fl  = bus_vld && bus_wr && bus_addr == ADDR_W'(2);
        wr_pin = wr_hi || wr_lo || wr_fl;
    end

    AST_HI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_LO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> ((pin_out & $past(bus_wdata)) == '0)); // R3
    AST_DRIVE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi || wr_lo) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata))); // R4
    AST_FLOAT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fl |=> (((pin_oe & $past(bus_wdata)) == '0) && $stable(pin_out))); // R5
    AST_NO_STRAY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pin |=> ($stable(pin_out) && $stable(pin_oe))); // R9
    AST_RVALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !bus_wr) |=> bus_rvalid); // R8
    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_vld && !bus_wr) |=> !bus_rvalid); // R8
    AST_DISARMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && !$past(seen_arm)) |-> (bus_rdata == '0)); // R7
endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_setclr_bank.sv
`timescale 1ns/1ps
// Bench: scoreboard for reads, direct port checks after writes.
module sim_gpio_setclr_bank;
    localparam int NP = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_vld = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NP-1:0] exp_q [$];
    string         tag_q [$];

    always #4 clk = ~clk;

    gpio_setclr_bank #(.NPINS(NP), .ADDR_W(AW)) u0 (.*);

    task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [NP-1:0] d);
        @(negedge clk);
        bus_vld = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_vld = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [NP-1:0] exp, string tag);
        @(negedge clk);
        bus_vld = 1; bus_wr = 0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        bus_vld = 0;
    endtask

    // Monitor: pop an expected item for every returned read.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8: unexpected rvalid, got %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic pins(string tag, logic [NP-1:0] eo, logic [NP-1:0] ee);
        check({tag, " pin_out"}, pin_out, eo);
        check({tag, " pin_oe"}, pin_oe, ee);
    endtask

    task automatic finish_run();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: missing read data, got %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        pin_in = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        pins("R1 reset", '0, '0);
        check("R1 rvalid", {31'b0, bus_rvalid}, '0);
        rst_n = 1;
        // R7: disarmed level read is zero
        rd(3'd3, '0, "R7 before arm");
        // R8: write-only register reads as zero
        rd(3'd0, '0, "R8 read drive-high");
        // R7: arm with arbitrary data
        wr(3'd4, 32'hDEAD_BEEF);
        rd(3'd3, 32'hFFFF_FFFF, "R7 after arm");
        // R2/R4: drive-high
        wr(3'd0, 32'h0000_00F0);
        pins("R2 R4 set F0", 32'h0000_00F0, 32'h0000_00F0);
        wr(3'd0, 32'h8000_0001);
        pins("R2 R4 set 80000001", 32'h8000_00F1, 32'h8000_00F1);
        // R3: drive-low
        wr(3'd1, 32'h0000_0030);
        pins("R3 clear 30", 32'h8000_00C1, 32'h8000_00F1);
        // R4: drive-low on undriven pin enables it
        wr(3'd1, 32'h0100_0000);
        pins("R4 clear enables", 32'h8000_00C1, 32'h8100_00F1);
        // R5: float
        wr(3'd2, 32'h8000_00F0);
        pins("R5 float", 32'h8000_00C1, 32'h0100_0001);
        // R9: writes to level and unmapped addresses
        wr(3'd3, 32'hFFFF_FFFF);
        pins("R9 write level", 32'h8000_00C1, 32'h0100_0001);
        wr(3'd6, 32'h0F0F_0F0F);
        pins("R9 write unmapped", 32'h8000_00C1, 32'h0100_0001);
        // R2: zero mask changes nothing
        wr(3'd0, 32'h0);
        pins("R2 zero mask", 32'h8000_00C1, 32'h0100_0001);
        // R6: synchronizer latency
        @(negedge clk);
        pin_in = 32'hA5A5_5A5A;
        rd(3'd3, 32'hFFFF_FFFF, "R6 one edge after change");
        rd(3'd3, 32'hA5A5_5A5A, "R6 settled");
        // R8: other readable addresses return zero
        rd(3'd1, '0, "R8 read drive-low");
        rd(3'd2, '0, "R8 read float");
        rd(3'd4, '0, "R8 read arm");
        rd(3'd7, '0, "R8 read unmapped");
        // R1/R7: second reset clears latches and the arm gate
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        pins("R1 second reset", '0, '0);
        rd(3'd3, '0, "R7 disarmed after reset");
        wr(3'd4, 32'h0);
        rd(3'd3, 32'hA5A5_5A5A, "R7 rearm with zero data");
        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule